// File: doc/BRIEF.md
# Pulse Period and Width Capture Unit

This block measures a single digital input signal. A programmable prescaler divides the system clock. The divided ticks drive a free-running up counter, and every active edge of the input restarts that counter from zero. The same input feeds two capture registers with opposite edge sense. The period register takes a sample on each active edge, and the width register takes a sample on each inactive edge. The period register therefore holds the time from one active edge to the next, and the width register holds the time the input spent in its active level. Both results are in prescaled ticks, so software does not need to subtract one sample from another.

Software controls the unit through a small strobe-based register file. One write port and one combinational read port cover the control word, the prescaler value, the status flags and the two capture results. Each capture sets a status flag. A single interrupt line is high while any flag is set together with its enable bit.

Register addresses: 0 is the control word (bit 0 run, bit 1 active-low select, bit 2 period interrupt enable, bit 3 width interrupt enable). 1 is the prescaler. 2 is the status word (bit 0 period flag, bit 1 width flag). 3 is the period capture (read only). 4 is the width capture (read only). Any other address reads as zero.

Top module: `pulse_capture`

## Requirements
- R1: With prescaler value P, the counter advances once every P+1 clocks. A measured interval of N clocks reads back as floor(N/(P+1)) ticks.
- R2: On each active edge the counter value including that clock's tick is copied to the period register (address 3), and the counter then restarts from zero. A steady pulse train with N clocks between active edges therefore reads floor(N/(P+1)).
- R3: On each inactive edge the counter value including that clock's tick is copied to the width register (address 4). W clocks of active level therefore read floor(W/(P+1)).
- R4: With control bit 1 clear, the active edge is rising and the width edge is falling. With control bit 1 set, both are reversed.
- R5: The counter is CNT_W bits wide and wraps to zero with no edge, so capture results are taken modulo 2^CNT_W.
- R6: A period capture sets status bit 0 and a width capture sets status bit 1. The irq output is high exactly while (status bit 0 and control bit 2) or (status bit 1 and control bit 3).
- R7: Writing the value zero to the status register clears both flags. A capture in the same cycle as that write keeps its flag set.
- R8: Reset and any control write with the run bit clear leave the unit stopped. When the run bit goes from 1 to 0, both flags and both interrupt enables are cleared. A control write that sets the run bit from 0 clears the flags. While stopped, the counter and prescaler stay at zero, and no capture or flag occurs.
- R9: Writing a nonzero value to the status register leaves the flags unchanged.
- R10: The input passes through a two-stage synchroniser. A level change applied before clock edge k is captured at clock edge k+2, so its flag reads set only after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Combinational read data |
| sig_in | input | 1 | Asynchronous signal under measurement |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with an 8-bit counter and the full 16-bit prescaler. The narrow counter brings wraparound within reach in a few hundred clocks, where a 16-bit counter would need tens of thousands. With this small counter the bench sweeps every pairing of the two polarities, the first four prescaler values and several period and width shapes, down to one-clock pulses. It computes the expected floor quotient for each case. Edge-exact checks then cover the synchroniser latency and a status clear that lands in the same cycle as a capture.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_PSC  = 3'd1,
        REG_STAT = 3'd2,
        REG_CAPP = 3'd3,
        REG_CAPW = 3'd4
    } reg_addr_e;

    // control word: bit3 width ie, bit2 period ie, bit1 active low, bit0 run
    typedef struct packed {
        logic ie_w;
        logic ie_p;
        logic act_low;
        logic run;
    } ctrl_t;

    // status word: bit1 width flag, bit0 period flag
    typedef struct packed {
        logic width;
        logic period;
    } flags_t;

    typedef struct packed {
        logic act;
        logic inact;
    } edges_t;

    function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run     = w[0];
        c.act_low = w[1];
        // enables only survive a write that keeps the unit running
        c.ie_p    = w[2] & w[0];
        c.ie_w    = w[3] & w[0];
        return c;
    endfunction

endpackage

// File: rtl/pwc_edge_detect.sv
module pwc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  logic             act_low,
    output pwc_pkg::edges_t  edges
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               lvl_now;
    logic               lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin};
    end

    assign lvl_now     = chain[SYNC_STAGES-1] ^ act_low;
    assign lvl_prev    = chain[SYNC_STAGES] ^ act_low;
    assign edges.act   = lvl_now & ~lvl_prev;
    assign edges.inact = ~lvl_now & lvl_prev;

endmodule

// File: rtl/pwc_timebase.sv
module pwc_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_next
);
    logic [PSC_W-1:0] psc_cnt;
    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick     = (psc_cnt >= psc);
    assign cnt_next = CNT_W'(cnt + CNT_W'(tick));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            psc_cnt <= '0;
            cnt     <= '0;
        end else begin
            psc_cnt <= (tick || restart) ? '0 : PSC_W'(psc_cnt + 1'b1);
            cnt     <= restart ? '0 : cnt_next;
        end
    end

    // R8: stopped unit holds counter and prescaler at zero
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && psc_cnt == '0));

    // R2: active edge restarts the count
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (run && restart) |=> (cnt == '0));

    // R1: counter moves by at most one tick per clock
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(restart)) |->
        (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/pwc_regs.sv
module pwc_regs
    import pwc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  edges_t            edges,
    input  logic [CNT_W-1:0]  cnt_next,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc,
    output logic              irq
);
    flags_t           flags;
    flags_t           flags_n;
    logic [CNT_W-1:0] cap_p;
    logic [CNT_W-1:0] cap_w;
    ctrl_t            ctrl_wr;
    logic             wr_ctrl;
    logic             wr_clr;
    logic             starting;
    logic             stopping;
    logic             evt_p;
    logic             evt_w;

    assign ctrl_wr  = ctrl_decode(wr_data);
    assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
    assign wr_clr   = wr_en && (wr_addr == REG_STAT) && (wr_data == '0);
    assign starting = wr_ctrl && ctrl_wr.run && !ctrl.run;
    assign stopping = wr_ctrl && !ctrl_wr.run && ctrl.run;
    assign evt_p    = ctrl.run && edges.act;
    assign evt_w    = ctrl.run && edges.inact;

    always_comb begin
        flags_n = wr_clr ? '0 : flags;
        flags_n.period = flags_n.period | evt_p;
        flags_n.width  = flags_n.width | evt_w;
        if (starting || stopping) flags_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            psc   <= '0;
            flags <= '0;
            cap_p <= '0;
            cap_w <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_wr;
            if (wr_en && wr_addr == REG_PSC) psc <= wr_data[PSC_W-1:0];
            flags <= flags_n;
            if (evt_p) cap_p <= cnt_next;
            if (evt_w) cap_w <= cnt_next;
        end
    end

    assign irq = (flags.period & ctrl.ie_p) | (flags.width & ctrl.ie_w);

    always_comb begin
        case (rd_addr)
            REG_CTRL: rd_data = DATA_W'(ctrl);
            REG_PSC:  rd_data = DATA_W'(psc);
            REG_STAT: rd_data = DATA_W'(flags);
            REG_CAPP: rd_data = DATA_W'(cap_p);
            REG_CAPW: rd_data = DATA_W'(cap_w);
            default:  rd_data = '0;
        endcase
    end

    // R6: a capture raises its flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_p && !stopping) |=> flags.period);

    // R7: status clear with no capture leaves both flags low
    p_status_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !evt_p && !evt_w) |=> (flags == '0));

    // R8: stopping drops flags, enables and the interrupt
    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        stopping |=> (flags == '0 && !ctrl.ie_p && !ctrl.ie_w && !irq));

    // R8: no flags exist while stopped
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> (flags == '0));

endmodule

// File: rtl/pulse_capture.sv
module pulse_capture #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic        sig_in,
    output logic        irq
);
    import pwc_pkg::*;

    edges_t           edges;
    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] cnt_next;

    pwc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin     (sig_in),
        .act_low (ctrl.act_low),
        .edges   (edges)
    );

    pwc_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .psc      (psc),
        .restart  (edges.act),
        .cnt_next (cnt_next)
    );

    pwc_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .edges    (edges),
        .cnt_next (cnt_next),
        .ctrl     (ctrl),
        .psc      (psc),
        .irq      (irq)
    );

endmodule

// File: tb/pulse_capture_test.sv
`timescale 1ns/1ps
module pulse_capture_test;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sig_in = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    logic pol = 1'b0;

    always #2.5 clk = ~clk;

    pulse_capture #(.CNT_W(CW), .PSC_W(16), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sig_in(sig_in), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // active level for w clocks, then inactive for n-w clocks
    task automatic pulse(input int w, input int n);
        sig_in = ~pol;
        idle(w);
        sig_in = pol;
        idle(n - w);
    endtask

    task automatic measure(input string req, input int psc, input int n, input int w);
        logic [15:0] v;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'(psc));
        sig_in = pol;
        idle(4);
        wr(3'd0, {14'd0, pol, 1'b1});
        for (int k = 0; k < 3; k++) pulse(w, n);
        idle(4);
        rd(3'd3, v);
        chk(req, $sformatf("period pol=%0d psc=%0d n=%0d", pol, psc, n), v,
            16'((n / (psc + 1)) % (1 << CW)));
        rd(3'd4, v);
        chk(req, $sformatf("width pol=%0d psc=%0d w=%0d", pol, psc, w), v,
            16'((w / (psc + 1)) % (1 << CW)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] cp;
        logic [15:0] cw;
        int shp_n[3] = '{12, 20, 9};
        int shp_w[3] = '{5, 1, 8};
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state (R8)
        rd(3'd0, v); chk("R8", "reset ctrl", v, 16'h0);
        rd(3'd2, v); chk("R8", "reset status", v, 16'h0);
        rd(3'd3, v); chk("R8", "reset period", v, 16'h0);
        chk("R8", "reset irq", 16'(irq), 16'h0);

        // R1 R2 R3 R4: polarity x prescaler x shape sweep
        for (int p = 0; p < 2; p++) begin
            pol = p[0];
            for (int ps = 0; ps < 4; ps++)
                for (int s = 0; s < 3; s++)
                    measure(p == 0 ? "R1/R2/R3" : "R4/R2/R3", ps, shp_n[s], shp_w[s]);
        end

        // R5: wraparound of the 8-bit counter
        pol = 1'b0;
        measure("R5", 0, 300, 10);
        measure("R5", 1, 600, 50);

        // R10: synchroniser latency, then R7 race
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h0);
        sig_in = 1'b0;
        idle(4);
        wr(3'd0, 16'h1);
        rd(3'd2, v); chk("R8", "status after start", v, 16'h0);
        sig_in = 1'b1;
        idle(2);
        rd(3'd2, v); chk("R10", "flag before third edge", v, 16'h0);
        idle(1);
        rd(3'd2, v); chk("R10", "flag after third edge", v, 16'h1);
        sig_in = 1'b0;
        idle(4);
        rd(3'd2, v); chk("R6", "both flags", v, 16'h3);
        wr(3'd2, 16'h3);
        rd(3'd2, v); chk("R9", "nonzero status write", v, 16'h3);
        // clear lands on the same edge as a period capture
        sig_in = 1'b1;
        idle(2);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0;
        idle(1);
        wr_en = 1'b0;
        rd(3'd2, v); chk("R7", "capture beats clear", v, 16'h1);
        wr(3'd2, 16'h0);
        rd(3'd2, v); chk("R7", "clear both", v, 16'h0);

        // R6: interrupt gating
        sig_in = 1'b0;
        idle(4);
        wr(3'd0, 16'h5);
        chk("R6", "irq width flag only, period ie", 16'(irq), 16'h0);
        sig_in = 1'b1;
        idle(4);
        chk("R6", "irq period flag with ie", 16'(irq), 16'h1);
        wr(3'd0, 16'h9);
        chk("R6", "irq period flag, width ie", 16'(irq), 16'h1);
        wr(3'd2, 16'h0);
        chk("R6", "irq after clear", 16'(irq), 16'h0);
        sig_in = 1'b0;
        idle(4);
        chk("R6", "irq width flag with ie", 16'(irq), 16'h1);

        // R8: stop clears flags and enables, then stays quiet
        wr(3'd0, 16'hC);
        rd(3'd0, v); chk("R8", "ctrl after stop", v, 16'h0);
        rd(3'd2, v); chk("R8", "status after stop", v, 16'h0);
        chk("R8", "irq after stop", 16'(irq), 16'h0);
        rd(3'd3, cp);
        rd(3'd4, cw);
        for (int k = 0; k < 3; k++) pulse(3, 7);
        idle(4);
        rd(3'd2, v); chk("R8", "no flags while stopped", v, 16'h0);
        rd(3'd3, v); chk("R8", "period held while stopped", v, cp);
        rd(3'd4, v); chk("R8", "width held while stopped", v, cw);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule